// File: doc/BRIEF.md
# Programmable Down-Counter/Timer Channel

This block is a single channel of a byte-programmed down-counter. A CPU-style write strobe delivers bytes to one register. Each byte is either a control byte or a time-constant byte. An internal flag records whether the next byte is a constant. The channel counts in one of two ways. In timer mode it counts system clocks through a 16- or 256-step prescaler. In counter mode it counts edges on an external trigger input, which is synchronized into the system clock domain. Each time the count runs out, the channel reloads its constant and raises a one-cycle zero pulse. It can also latch an interrupt request that stays set until acknowledged.

Software first writes a control byte that asks for a constant, then writes the constant. A soft-reset bit stops the channel until a fresh constant arrives. A constant written while the channel runs is held back until the current period ends.

Top module: `ctmr_channel`

## Requirements
- R1: When no constant is pending, a written byte with bit 0 clear is ignored: configuration, count and interrupt state are unchanged.
- R2: A control byte (bit 0 set) with bit 2 set makes the very next write a time constant, whatever that byte's bit 0 holds.
- R3: A control byte with bit 1 set stops the channel; no zero pulse follows until a new constant is written.
- R4: After reset the channel does not count until a time constant has been written, even if control bytes are written.
- R5: A time constant of 0 counts 256 steps.
- R6: A constant written while the channel runs does not change the period in progress; it applies from the next terminal count onward.
- R7: In timer mode (bit 6 clear) one step is 16 system clocks with bit 5 clear or 256 with bit 5 set. With automatic start, the first zero pulse comes exactly N×prescale cycles after the clock edge that accepts constant N.
- R8: In counter mode (bit 6 set) a step is one edge of the external input, rising when bit 4 is 1 and falling when 0. The zero pulse appears on the third clock edge after the input changes.
- R9: In timer mode with bit 3 clear timing starts when the constant is accepted. With bit 3 set it waits for the active external edge, and the first zero pulse comes 3 + N×prescale cycles after the input change.
- R10: A control byte with bit 1 clear leaves a running channel counting without a break.
- R11: The zero pulse is high for exactly one cycle, and the channel reloads and keeps running, giving a steady period.
- R12: With bit 7 set, a zero pulse sets the interrupt request, which stays high until an acknowledge cycle. With bit 7 clear no request is raised, and writing 0x01 clears bit 7 without stopping the channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe, one byte per high cycle |
| wr_data_i | input | 8 | Written byte (control or constant) |
| ext_trg_i | input | 1 | External clock/trigger, asynchronous, at most half the clock rate |
| irq_ack_i | input | 1 | Clears the interrupt request |
| zero_pulse_o | output | 1 | One-cycle pulse at each terminal count |
| irq_o | output | 1 | Level interrupt request |

## Verification
The assertions check the following on every cycle:
- the zero pulse and the prescaler tick never last more than one cycle;
- the down-counter is never zero while running;
- the channel cannot run before a constant exists;
- an accepted constant clears the pending flag;
- the interrupt request only rises together with a zero pulse and holds until acknowledged.

Some behaviour only the bench scenarios can show. These are the exact cycle of each zero pulse under both prescalers, the 256 meaning of a zero constant, and the deferred reload of a constant changed mid-run. They also include edge polarity in counter mode, trigger-started timing, the effect of the soft reset, and the ignored non-control bytes.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;

  // Control byte bit positions; software encodes against these.
  localparam int CB_IRQ_EN  = 7;
  localparam int CB_COUNTER = 6;
  localparam int CB_PS_HI   = 5;
  localparam int CB_RISE    = 4;
  localparam int CB_TRIG    = 3;
  localparam int CB_TC_NEXT = 2;
  localparam int CB_SOFTRST = 1;
  localparam int CB_CTRL    = 0;

  localparam int BYTE_W = 8;
  localparam int CNT_W  = BYTE_W + 1;

  typedef struct packed {
    logic irq_en;
    logic cnt_mode;
    logic ps_hi;
    logic rise;
    logic trig_start;
  } ctmr_cfg_t;

  // A constant of zero stands for a full 2**BYTE_W steps.
  function automatic logic [CNT_W-1:0] tc_expand(input logic [BYTE_W-1:0] v);
    if (v == '0) tc_expand = CNT_W'(1) << BYTE_W;
    else         tc_expand = {1'b0, v};
  endfunction

endpackage

// File: rtl/ctmr_wr_decode.sv
module ctmr_wr_decode
  import ctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  output ctmr_cfg_t         cfg,
  output logic              soft_rst,
  output logic              tc_wr,
  output logic [BYTE_W-1:0] tc_val
);

  logic      pend_q, pend_n;
  ctmr_cfg_t cfg_q, cfg_n;
  logic      is_tc, is_ctl;

  always_comb begin
    is_tc  = wr_en & pend_q;
    is_ctl = wr_en & ~pend_q & wr_data[CB_CTRL];
    pend_n = pend_q;
    cfg_n  = cfg_q;
    if (is_tc) begin
      pend_n = 1'b0;
    end else if (is_ctl) begin
      pend_n           = wr_data[CB_TC_NEXT];
      cfg_n.irq_en     = wr_data[CB_IRQ_EN];
      cfg_n.cnt_mode   = wr_data[CB_COUNTER];
      cfg_n.ps_hi      = wr_data[CB_PS_HI];
      cfg_n.rise       = wr_data[CB_RISE];
      cfg_n.trig_start = wr_data[CB_TRIG];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      cfg_q  <= '0;
    end else if (wr_en) begin
      pend_q <= pend_n;
      cfg_q  <= cfg_n;
    end
  end

  assign cfg      = cfg_q;
  assign soft_rst = is_ctl & wr_data[CB_SOFTRST];
  assign tc_wr    = is_tc;
  assign tc_val   = wr_data;

  // R2
  tc_consumes_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && pend_q) |=> !pend_q);

endmodule

// File: rtl/ctmr_edge_sync.sv
module ctmr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ext,
  input  logic rise_sel,
  output logic edge_o
);

  logic [STAGES:0] sh_q, sh_n;
  logic            cur, prev;

  always_comb begin
    sh_n = {sh_q[STAGES-1:0], ext};
    cur  = sh_q[STAGES-1];
    prev = sh_q[STAGES];
    edge_o = rise_sel ? (cur & ~prev) : (~cur & prev);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_n;
  end

  // R8
  edge_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (edge_o && $stable(rise_sel)) |=> !(edge_o && $stable(rise_sel)));

endmodule

// File: rtl/ctmr_prescaler.sv
module ctmr_prescaler #(
  parameter int PS_LO = 16,
  parameter int PS_HI = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic sel_hi,
  output logic tick
);

  localparam int W = $clog2(PS_HI);
  localparam logic [W-1:0] LO_TOP = W'(PS_LO - 1);
  localparam logic [W-1:0] HI_TOP = W'(PS_HI - 1);

  logic [W-1:0] pre_q, pre_n;

  always_comb begin
    tick  = run & (pre_q == (sel_hi ? HI_TOP : LO_TOP));
    if (!run || tick) pre_n = '0;
    else              pre_n = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pre_q <= '0;
    else        pre_q <= pre_n;
  end

  // R7
  tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);

endmodule

// File: rtl/ctmr_down_core.sv
module ctmr_down_core
  import ctmr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_en,
  input  logic              cnt_mode,
  input  logic              trig_start,
  input  logic              soft_rst,
  input  logic              tc_wr,
  input  logic [BYTE_W-1:0] tc_val,
  input  logic              tmr_tick,
  input  logic              ext_edge,
  input  logic              irq_ack,
  output logic              run,
  output logic              zero_pulse,
  output logic              irq
);

  logic              run_q, run_n, arm_q, arm_n, have_q, have_n;
  logic [BYTE_W-1:0] tc_q, tc_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              zc_q, zc_n, irq_q, irq_n;
  logic              dec;

  always_comb begin
    run_n  = run_q;
    arm_n  = arm_q;
    have_n = have_q;
    tc_n   = tc_q;
    cnt_n  = cnt_q;
    zc_n   = 1'b0;
    dec    = run_q & (cnt_mode ? ext_edge : tmr_tick);

    if (soft_rst) begin
      // R3: stop, keep the stored constant
      run_n = 1'b0;
      arm_n = 1'b0;
    end else if (tc_wr) begin
      tc_n   = tc_val;
      have_n = 1'b1;
      if (!run_q) begin
        // R9: immediate start or wait for trigger
        cnt_n = tc_expand(tc_val);
        if (cnt_mode || !trig_start) begin
          run_n = 1'b1;
          arm_n = 1'b0;
        end else begin
          arm_n = 1'b1;
        end
      end
    end else if (arm_q && ext_edge) begin
      run_n = 1'b1;
      arm_n = 1'b0;
    end

    // R6: reload uses the constant held before this cycle's write
    if (dec && !soft_rst) begin
      if (cnt_q == CNT_W'(1)) begin
        cnt_n = tc_expand(tc_q);
        zc_n  = 1'b1;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end

    irq_n = (zc_n & irq_en) | (irq_q & ~irq_ack);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      arm_q  <= 1'b0;
      have_q <= 1'b0;
      tc_q   <= '0;
      cnt_q  <= '0;
      zc_q   <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      run_q  <= run_n;
      arm_q  <= arm_n;
      have_q <= have_n;
      tc_q   <= tc_n;
      cnt_q  <= cnt_n;
      zc_q   <= zc_n;
      irq_q  <= irq_n;
    end
  end

  assign run        = run_q;
  assign zero_pulse = zc_q;
  assign irq        = irq_q;

  // R4
  no_run_without_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !have_q |-> !run_q);

  // R5
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q |-> (cnt_q != '0));

  // R11
  zero_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zc_q |=> !zc_q);

  // R12
  irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_ack) |=> irq_q);

  // R12
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_q) |-> zc_q);

endmodule

// File: rtl/ctmr_channel.sv
module ctmr_channel
  import ctmr_pkg::*;
#(
  parameter int PS_LO       = 16,
  parameter int PS_HI       = 256,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              ext_trg_i,
  input  logic              irq_ack_i,
  output logic              zero_pulse_o,
  output logic              irq_o
);

  logic [1:0]        rst_sh_q;
  logic              rst_n;
  ctmr_cfg_t         cfg;
  logic              soft_rst, tc_wr, tmr_tick, ext_edge, run;
  logic [BYTE_W-1:0] tc_val;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rst_sh_q <= '0;
    else         rst_sh_q <= {rst_sh_q[0], 1'b1};
  end
  assign rst_n = rst_sh_q[1];

  ctmr_wr_decode u_dec (
    .clk      (clk_i),
    .rst_n    (rst_n),
    .wr_en    (wr_en_i),
    .wr_data  (wr_data_i),
    .cfg      (cfg),
    .soft_rst (soft_rst),
    .tc_wr    (tc_wr),
    .tc_val   (tc_val)
  );

  ctmr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk_i),
    .rst_n    (rst_n),
    .ext      (ext_trg_i),
    .rise_sel (cfg.rise),
    .edge_o   (ext_edge)
  );

  ctmr_prescaler #(.PS_LO(PS_LO), .PS_HI(PS_HI)) u_pre (
    .clk    (clk_i),
    .rst_n  (rst_n),
    .run    (run),
    .sel_hi (cfg.ps_hi),
    .tick   (tmr_tick)
  );

  ctmr_down_core u_core (
    .clk        (clk_i),
    .rst_n      (rst_n),
    .irq_en     (cfg.irq_en),
    .cnt_mode   (cfg.cnt_mode),
    .trig_start (cfg.trig_start),
    .soft_rst   (soft_rst),
    .tc_wr      (tc_wr),
    .tc_val     (tc_val),
    .tmr_tick   (tmr_tick),
    .ext_edge   (ext_edge),
    .irq_ack    (irq_ack_i),
    .run        (run),
    .zero_pulse (zero_pulse_o),
    .irq        (irq_o)
  );

endmodule

// File: tb/sim_ctmr_channel.sv
`timescale 1ns/1ps
module sim_ctmr_channel;

  logic       clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, ack = 1'b0, ext = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       zc, irq;

  int    cyc = 0, n_chk = 0, n_fail = 0, zc_cnt = 0;
  int    exp_q[$];
  string tag_q[$];

  ctmr_channel u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_data_i(wr_data),
    .ext_trg_i(ext), .irq_ack_i(ack), .zero_pulse_o(zc), .irq_o(irq)
  );

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic push(input int c, input string t);
    exp_q.push_back(c);
    tag_q.push_back(t);
  endtask

  task automatic wr(input logic [7:0] b, output int cw);
    @(negedge clk); wr_en = 1'b1; wr_data = b;
    @(negedge clk); wr_en = 1'b0; cw = cyc;
  endtask

  task automatic wait_to(input int t);
    while (cyc < t) @(negedge clk);
  endtask

  task automatic ack_pulse();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  // One high/low pulse of the external input; expected zero pulses are
  // queued at the selected edge: edge + 3 + dly + k*per, k < n.
  task automatic pulse(input bit er, input bit ef, input int dly, input int per,
                       input int n, input string t);
    @(negedge clk); ext = 1'b1;
    if (er) for (int k = 0; k < n; k++) push(cyc + 3 + dly + k * per, t);
    repeat (3) @(negedge clk);
    ext = 1'b0;
    if (ef) for (int k = 0; k < n; k++) push(cyc + 3 + dly + k * per, t);
    repeat (3) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard on every observed zero pulse
  always @(negedge clk) begin : mon
    int    e;
    string t;
    if (rst_n && zc) begin
      zc_cnt++;
      if (exp_q.size() == 0) begin
        check(1'b0, "R11", "unexpected zero pulse at cycle", cyc, -1);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cyc == e, t, "zero pulse cycle", cyc, e);
      end
    end
  end

  initial begin : watchdog
    #800000;
    check(1'b0, "WDOG", "watchdog expired at cycle", cyc, 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin : drive
    int cw, z0, d;
    repeat (3) @(negedge clk);
    check(zc == 1'b0, "R11", "zero pulse in reset", zc, 0);
    check(irq == 1'b0, "R12", "irq in reset", irq, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: bit0-clear bytes with nothing pending are dropped
    z0 = zc_cnt;
    wr(8'h04, d); wr(8'h02, d);
    repeat (300) @(negedge clk);
    check(zc_cnt == z0, "R1", "pulses after ignored bytes", zc_cnt, z0);
    // R4: control without constant does not start
    wr(8'h01, d);
    repeat (600) @(negedge clk);
    check(zc_cnt == z0, "R4", "pulses without constant", zc_cnt, z0);

    // R2/R7/R12: 0x03 accepted as constant 3, prescale 16
    wr(8'h85, d); wr(8'h03, cw);
    push(cw + 48, "R2"); push(cw + 96, "R11");
    wait_to(cw + 50);
    check(irq == 1'b1, "R12", "irq after zero", irq, 1);
    ack_pulse();
    check(irq == 1'b0, "R12", "irq after ack", irq, 0);
    wait_to(cw + 98);
    check(irq == 1'b1, "R12", "irq second period", irq, 1);
    // R3: soft reset stops counting
    z0 = zc_cnt;
    wr(8'h03, d);
    repeat (200) @(negedge clk);
    check(zc_cnt == z0, "R3", "pulses after soft reset", zc_cnt, z0);
    check(irq == 1'b1, "R12", "irq held without ack", irq, 1);
    ack_pulse();
    check(irq == 1'b0, "R12", "irq cleared", irq, 0);

    // R5: constant 0 -> 256 steps
    wr(8'h07, d); wr(8'h00, cw);
    push(cw + 4096, "R5");
    wait_to(cw + 4100);
    check(irq == 1'b0, "R12", "irq with enable clear", irq, 0);
    // R7: prescale 256
    wr(8'h27, d); wr(8'h02, cw);
    push(cw + 512, "R7"); push(cw + 1024, "R7");
    wait_to(cw + 1030);
    wr(8'h03, d);

    // R6/R10: new constant mid-run applies at next terminal count
    wr(8'h05, d); wr(8'h04, cw);
    push(cw + 64, "R10"); push(cw + 96, "R6"); push(cw + 128, "R6");
    wait_to(cw + 20);
    wr(8'h05, d); wr(8'h02, d);
    wait_to(cw + 132);
    wr(8'h03, d);

    // R8: counter mode, rising edges, constant 3
    wr(8'h57, d); wr(8'h03, d);
    for (int i = 0; i < 6; i++) pulse(i == 2 || i == 5, 1'b0, 0, 0, 1, "R8");
    repeat (10) @(negedge clk);
    wr(8'h03, d);
    // R8: counter mode, falling edges, constant 2
    wr(8'h47, d); wr(8'h02, d);
    for (int i = 0; i < 4; i++) pulse(1'b0, i == 1 || i == 3, 0, 0, 1, "R8");
    repeat (10) @(negedge clk);
    wr(8'h03, d);

    // R9: trigger-started timer, constant 1
    z0 = zc_cnt;
    wr(8'h1F, d); wr(8'h01, d);
    repeat (100) @(negedge clk);
    check(zc_cnt == z0, "R9", "pulses before trigger", zc_cnt, z0);
    pulse(1'b1, 1'b0, 16, 16, 2, "R9");
    repeat (40) @(negedge clk);
    wr(8'h03, d);

    // R1/R12: ignored byte mid-run, 0x01 drops enable but keeps running
    wr(8'h85, d); wr(8'h02, cw);
    push(cw + 32, "R12"); push(cw + 64, "R1"); push(cw + 96, "R12");
    wait_to(cw + 34);
    check(irq == 1'b1, "R12", "irq set", irq, 1);
    ack_pulse();
    wr(8'h00, d);
    wait_to(cw + 66);
    check(irq == 1'b1, "R1", "enable kept after ignored byte", irq, 1);
    ack_pulse();
    wr(8'h01, d);
    wait_to(cw + 98);
    check(irq == 1'b0, "R12", "irq after 0x01", irq, 0);
    wr(8'h03, d);

    repeat (20) @(negedge clk);
    check(exp_q.size() == 0, "R11", "missing zero pulses", exp_q.size(), 0);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule